// File: doc/BRIEF.md
# Instruction-Fetch Patch Redirect Unit

This block lets software replace a faulty instruction in read-only program memory with code held in RAM. It watches the opcode-fetch address the processor core presents. When that address equals a patch address loaded into an enabled channel, the block raises a redirect pulse in the same cycle. Alongside the pulse it drives the fixed start of that channel's 32-byte RAM patch window. The core loads this target into its program counter. The code placed in the window must end with a jump back into main memory.

There are two channels. Each has a 16-bit patch address, which is written and read as a high byte and a low byte on a byte-wide register bus. A shared enable register holds one enable bit per channel. Register reads are combinational on the bus address and writes land on the next clock edge. The fetch side is a plain strobe with no ready signal: the core cannot be stalled, so a redirect is a single-cycle indication with no back-pressure. The result has to be consumed in the cycle it appears.

Top module: `fetch_patch_redirect`

## Requirements
- R1: After reset the enable register and both patch address registers read 0, and no fetch (including one at 0x0000) produces a redirect.
- R2: Register addresses are as follows. The enable register is at 0x0212. Channel 1 high and low bytes are at 0x0217 and 0x0218, and channel 2 high and low bytes are at 0x0219 and 0x021A. Reads are combinational and any other address reads 0x00. A write takes effect at the clock edge that ends the write cycle, so a fetch in that same cycle still sees the old setting.
- R3: In the enable register, bit 0 enables channel 1 and bit 1 enables channel 2. Bits 2 and 3 are stored and read back but have no effect on redirects. Bits 7 to 4 ignore writes and read 0.
- R4: A fetch strobe whose address equals an enabled channel 1 address raises `redirect` in that cycle with `redirect_target` = 0x02C0.
- R5: A fetch strobe whose address equals an enabled channel 2 address raises `redirect` in that cycle with `redirect_target` = 0x02E0.
- R6: A channel whose enable bit is 0 never causes a redirect, whatever its address register holds.
- R7: Only cycles with `fetch_valid` = 1 are compared. A matching address with the strobe low gives no redirect.
- R8: The comparison covers all 16 address bits. A fetch address that differs from the patch address in either the high byte or the low byte gives no redirect.
- R9: When both enabled channels match the same fetch, channel 1 wins and the target is 0x02C0.
- R10: `redirect` is high only in cycles with a matching strobe, and for one cycle per such strobe. While `redirect` is low, `redirect_target` is 0x0000.
- R11: Fetches from inside a patch window are compared like any other fetch. The block keeps no in-patch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register bus address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| fetch_valid | input | 1 | Opcode-fetch strobe from the core |
| fetch_addr | input | 16 | Opcode-fetch address |
| redirect | output | 1 | Redirect pulse, same cycle as the matching strobe |
| redirect_target | output | 16 | Patch window start while redirect is high, else 0 |

## Verification
The main function is exercised with the following fetch streams:
- Exact hits on each channel separate the two targets.
- Near misses in the high byte and in the low byte show that the comparison is the full width and not a partial one.
- Equal addresses with the strobe low separate fetch cycles from other bus cycles.
- Enable patterns 0x00, 0x0C, 0x01, 0x02 and 0x03 tell apart the per-channel gating, the inert reserved bits and the priority when both channels hold the same address.
- A hit issued in the very cycle that clears the enable pins down when a write lands.
- A hit inside a patch window shows that the block keeps no hidden state.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  // Enable register bits that hold state (channel enables plus two inert bits).
  localparam int EN_STORED_BITS = 4;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/fpr_regfile.sv
module fpr_regfile #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int NCH = 2,
  parameter logic [AW-1:0] EN_ADDR = 16'h0212,
  parameter logic [AW-1:0] PA_BASE = 16'h0217
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  output logic [NCH-1:0]         en_bits,
  output logic [NCH-1:0][AW-1:0] pa_vec
);
  import fpr_pkg::*;
  localparam int ENW = EN_STORED_BITS;

  logic [ENW-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en && addr == EN_ADDR) en_q <= wdata[ENW-1:0];
  end
  assign en_bits = en_q[NCH-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_pa
    localparam logic [AW-1:0] HI_A = PA_BASE + AW'(2 * c);
    localparam logic [AW-1:0] LO_A = PA_BASE + AW'(2 * c + 1);
    logic [AW-1:0] pa_q;
    always_ff @(posedge clk) begin
      if (!rst_n) pa_q <= '0;
      else if (wr_en && addr == HI_A) pa_q[AW-1:AW-DW] <= wdata;
      else if (wr_en && addr == LO_A) pa_q[DW-1:0] <= wdata;
    end
    assign pa_vec[c] = pa_q;
  end

  always_comb begin
    rdata = '0;
    if (addr == EN_ADDR) rdata[ENW-1:0] = en_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr == PA_BASE + AW'(2 * c))     rdata = pa_vec[c][AW-1:AW-DW];
      if (addr == PA_BASE + AW'(2 * c + 1)) rdata = pa_vec[c][DW-1:0];
    end
  end
endmodule

// File: rtl/fpr_match_chan.sv
module fpr_match_chan #(
  parameter int AW = 16
) (
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          enable,
  input  logic [AW-1:0] patch_addr,
  output logic          hit
);
  assign hit = fetch_valid && enable && (fetch_addr == patch_addr);
endmodule

// File: rtl/fpr_arbiter.sv
module fpr_arbiter #(
  parameter int AW = 16,
  parameter int NCH = 2,
  parameter logic [AW-1:0] WIN_BASE = 16'h02C0,
  parameter int WIN_BYTES = 32
) (
  input  logic [NCH-1:0] hits,
  output logic           redirect,
  output logic [AW-1:0]  target
);
  // Scan from the highest index down so the lowest index wins.
  always_comb begin
    redirect = 1'b0;
    target   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hits[i]) begin
        redirect = 1'b1;
        target   = WIN_BASE + AW'(i * WIN_BYTES);
      end
    end
  end
endmodule

// File: rtl/fetch_patch_redirect.sv
module fetch_patch_redirect #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] EN_ADDR = 16'h0212,
  parameter logic [AW-1:0] PA_BASE = 16'h0217,
  parameter logic [AW-1:0] WIN_BASE = 16'h02C0,
  parameter int WIN_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  output logic          redirect,
  output logic [AW-1:0] redirect_target
);
  import fpr_pkg::*;
  localparam int NCH = NUM_CH;

  logic [NCH-1:0]         en_bits;
  logic [NCH-1:0][AW-1:0] pa_vec;
  logic [NCH-1:0]         hits;

  fpr_regfile #(.AW(AW), .DW(DW), .NCH(NCH), .EN_ADDR(EN_ADDR), .PA_BASE(PA_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_bits(en_bits), .pa_vec(pa_vec)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    fpr_match_chan #(.AW(AW)) u_match (
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .enable(en_bits[c]), .patch_addr(pa_vec[c]), .hit(hits[c])
    );
  end

  fpr_arbiter #(.AW(AW), .NCH(NCH), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_arb (
    .hits(hits), .redirect(redirect), .target(redirect_target)
  );
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [15:0]      reg_addr,
  input logic [7:0]       reg_wdata,
  input logic [7:0]       reg_rdata,
  input logic             fetch_valid,
  input logic [15:0]      fetch_addr,
  input logic             redirect,
  input logic [15:0]      redirect_target,
  input logic [1:0]       en_bits,
  input logic [1:0][15:0] pa_vec
);
  // R7
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> fetch_valid);
  // R10
  idle_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> redirect_target == 16'h0000);
  // R4
  ch1_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && redirect_target == 16'h02C0) |-> (en_bits[0] && fetch_addr == pa_vec[0]));
  // R5
  ch2_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && redirect_target == 16'h02E0) |-> (en_bits[1] && fetch_addr == pa_vec[1]));
  // R9
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && en_bits[0] && fetch_addr == pa_vec[0]) |-> (redirect && redirect_target == 16'h02C0));
  // R3
  hi_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 16'h0212) |-> reg_rdata[7:4] == 4'h0);
  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 16'h0212) |=> en_bits == $past(reg_wdata[1:0]));
  // R6
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bits == 2'b00) |-> !redirect);
endmodule

bind fetch_patch_redirect fpr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .redirect(redirect), .redirect_target(redirect_target), .en_bits(en_bits), .pa_vec(pa_vec)
);

// File: tb/sim_fetch_patch_redirect.sv
module sim_fetch_patch_redirect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        redirect;
  logic [15:0] redirect_target;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  fetch_patch_redirect u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .redirect(redirect), .redirect_target(redirect_target)
  );

  // Monitor: one expected item per driven cycle, compared mid-cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({redirect, redirect_target} !== e) begin
        errors++;
        $display("FAIL %s: redirect/target got %0b/%h expected %0b/%h",
                 t, redirect, redirect_target, e[16], e[15:0]);
      end
    end
  end

  task automatic drive_cycle(input logic v, input logic [15:0] a,
                             input logic er, input logic [15:0] et, input string t);
    @(posedge clk); #1;
    fetch_valid = v;
    fetch_addr  = a;
    reg_wr      = 1'b0;
    exp_q.push_back({er, et});
    tag_q.push_back(t);
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    fetch_valid = 1'b0;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [15:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s: rdata @%h got %h expected %h", t, a, reg_rdata, e);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    fetch_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    reg_check(16'h0212, 8'h00, "R1 enable");
    reg_check(16'h0217, 8'h00, "R1 ch1 hi");
    reg_check(16'h0218, 8'h00, "R1 ch1 lo");
    reg_check(16'h0219, 8'h00, "R1 ch2 hi");
    reg_check(16'h021A, 8'h00, "R1 ch2 lo");
    drive_cycle(1, 16'h0000, 0, 16'h0000, "R1 fetch 0000 after reset");
    idle();
    // R2 register map
    reg_write(16'h0217, 8'h12); reg_write(16'h0218, 8'h34);
    reg_write(16'h0219, 8'hAB); reg_write(16'h021A, 8'hCD);
    reg_check(16'h0217, 8'h12, "R2 ch1 hi");
    reg_check(16'h0218, 8'h34, "R2 ch1 lo");
    reg_check(16'h0219, 8'hAB, "R2 ch2 hi");
    reg_check(16'h021A, 8'hCD, "R2 ch2 lo");
    reg_check(16'h0213, 8'h00, "R2 unmapped 0213");
    reg_check(16'h021B, 8'h00, "R2 unmapped 021B");
    // R3 enable readback
    reg_write(16'h0212, 8'hFF);
    reg_check(16'h0212, 8'h0F, "R3 upper bits read 0");
    // R4 R5 R8 R7 R10
    drive_cycle(1, 16'h1234, 1, 16'h02C0, "R4 ch1 hit");
    drive_cycle(0, 16'h0000, 0, 16'h0000, "R10 pulse ends");
    drive_cycle(1, 16'hABCD, 1, 16'h02E0, "R5 ch2 hit");
    drive_cycle(1, 16'h1235, 0, 16'h0000, "R8 low byte differs");
    drive_cycle(1, 16'h1334, 0, 16'h0000, "R8 high byte differs");
    drive_cycle(0, 16'h1234, 0, 16'h0000, "R7 no strobe");
    drive_cycle(1, 16'h1234, 1, 16'h02C0, "R10 back-to-back 1");
    drive_cycle(1, 16'h1234, 1, 16'h02C0, "R10 back-to-back 2");
    idle();
    // R3 reserved bits inert, R6 disabled channels
    reg_write(16'h0212, 8'h0C);
    reg_check(16'h0212, 8'h0C, "R3 reserved bits stored");
    drive_cycle(1, 16'h1234, 0, 16'h0000, "R3 reserved bits no effect ch1");
    drive_cycle(1, 16'hABCD, 0, 16'h0000, "R6 ch2 disabled");
    idle();
    reg_write(16'h0212, 8'h02);
    drive_cycle(1, 16'h1234, 0, 16'h0000, "R6 ch1 disabled");
    drive_cycle(1, 16'hABCD, 1, 16'h02E0, "R5 ch2 alone");
    idle();
    // R9 priority
    reg_write(16'h0219, 8'h12); reg_write(16'h021A, 8'h34);
    reg_write(16'h0212, 8'h03);
    drive_cycle(1, 16'h1234, 1, 16'h02C0, "R9 both match ch1 wins");
    idle();
    reg_write(16'h0212, 8'h02);
    drive_cycle(1, 16'h1234, 1, 16'h02E0, "R9 ch2 when ch1 off");
    idle();
    // R11 fetch inside patch window
    reg_write(16'h0217, 8'h02); reg_write(16'h0218, 8'hC5);
    reg_write(16'h0212, 8'h01);
    drive_cycle(1, 16'h02C5, 1, 16'h02C0, "R11 hit inside window");
    drive_cycle(1, 16'h02C6, 0, 16'h0000, "R11 next window fetch");
    idle();
    // R2 write lands at the end of its cycle
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 16'h0212; reg_wdata = 8'h00;
    fetch_valid = 1'b1; fetch_addr = 16'h02C5;
    exp_q.push_back({1'b1, 16'h02C0}); tag_q.push_back("R2 old enable in write cycle");
    drive_cycle(1, 16'h02C5, 0, 16'h0000, "R2 new enable after edge");
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule